// File: doc/BRIEF.md
# Multiplexed Host Memory Bus Bridge

This block sits between a small processor core and an external host that supplies memory, I/O and the clock. A single bus carries the address in one cycle and the data in the following cycle. The core raises one of three request lines: read, write or halt. If the bridge is idle it accepts the request, then runs the matching phases on the host side with the strobes the host expects. Read data is captured at the end of the data phase and held for the core until the next read completes.

An instruction path is included. A read marked as a fetch lets the data flow straight through to the instruction output during the data phase, and then holds the captured word. A halt request shows a reason code on the bus for one cycle with the halted flag raised, so the host can stop the clock and later resume it. The host interrupt request reaches the core through one register.

The bus is modelled as separate input, output and output-enable pins. The output enable selects when the bridge drives the bus and when it leaves it to the host.

Top module: `hbus_bridge`

## Requirements
- R1: While rst_ni is low and after it rises, with no request made, mem_rd_o, mem_wr_o, halted_o, word_o, bus_oe_o, core_busy_o and core_rvalid_o are 0, and core_rdata_o and core_ir_o are 0.
- R2: In the cycle after an idle bridge accepts a read, the read address phase runs: mem_rd_o=1, bus_oe_o=1, bus_o equals the request address and word_o equals core_word_i. The phase lasts exactly one cycle.
- R3: In the read data phase (the next cycle) the bus is released (bus_oe_o=0) and both strobes are 0. bus_i is captured at the end of that cycle. In the cycle after the data phase, core_rvalid_o is 1 for one cycle and core_rdata_o shows the captured value. core_rdata_o then holds that value, whatever bus_i does, until the next read completes.
- R4: A byte access (core_word_i=0) returns bus_i[7:0] in core_rdata_o[7:0] with bits 15:8 zero. A byte write drives the data bits 15:8 as zero in its data phase.
- R5: In the cycle after a write is accepted, mem_wr_o=1, bus_oe_o=1 and bus_o is the address. In the next cycle bus_o is the write data, bus_oe_o=1 and mem_wr_o=0.
- R6: For a read with core_fetch_i=1, core_ir_o equals the masked bus_i during the read data phase and keeps the captured value afterwards. A read with core_fetch_i=0 leaves core_ir_o unchanged.
- R7: In the cycle after a halt is accepted, halted_o=1, bus_oe_o=1, word_o=1 and bus_o equals core_reason_i. In the following cycle the bridge is idle again with halted_o=0.
- R8: bus_oe_o is 0 in every cycle that is not a read address phase, a write address phase, a write data phase or a halt phase.
- R9: A request is accepted only while core_busy_o=0, and requests made while busy are ignored. When several requests arrive together, write wins over read and read wins over halt. mem_rd_o and mem_wr_o are never 1 in the same cycle.
- R10: core_busy_o is 1 in every phase cycle of a transaction and 0 otherwise.
- R11: core_irq_o equals irq_i delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock supplied by the host |
| rst_ni | input | 1 | Active-low asynchronous reset from the host |
| irq_i | input | 1 | Interrupt request from the host |
| core_rd_i | input | 1 | Core read request |
| core_wr_i | input | 1 | Core write request |
| core_halt_i | input | 1 | Core halt request |
| core_word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| core_fetch_i | input | 1 | Read is an instruction fetch |
| core_addr_i | input | 16 | Access address |
| core_wdata_i | input | 16 | Write data |
| core_reason_i | input | 16 | Halt reason code |
| core_busy_o | output | 1 | Transaction in progress |
| core_rdata_o | output | 16 | Held read data |
| core_rvalid_o | output | 1 | One-cycle pulse when new read data is valid |
| core_ir_o | output | 16 | Instruction word |
| core_irq_o | output | 1 | Registered interrupt request |
| bus_i | input | 16 | Shared bus as driven by the host |
| bus_o | output | 16 | Shared bus value driven by the bridge |
| bus_oe_o | output | 1 | Bridge drives the bus when 1 |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| word_o | output | 1 | Width of the current access |
| halted_o | output | 1 | Halt phase indicator |

## Verification
A sequencer in the wrong state shows up within one cycle as a strobe with no accepted request, a bus that stays driven into the read data phase, or an address phase that lasts two cycles. A wrong width register shows up in the next data phase, as nonzero upper read bits or a corrupted upper byte in host memory. The host model keeps its own byte array and read-back expectations come from the bench's shadow copy. Any misdirected write or mis-merged byte therefore appears as a wrong core_rdata_o value on a later read, not only during the write itself.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_DATA,
    ST_WR_ADDR,
    ST_WR_DATA,
    ST_HALT
  } hbus_state_e;
endpackage

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          halt_i,
  input  logic          word_i,
  input  logic          fetch_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] reason_i,
  output hbus_state_e   state_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          word_o,
  output logic          fetch_o,
  output logic [DW-1:0] lane_mask_o
);
  localparam int LANES = DW / 8;

  hbus_state_e state_q;
  logic [DW-1:0] addr_q, data_q;
  logic word_q, fetch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      word_q  <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          // write > read > halt
          if (wr_i) begin
            state_q <= ST_WR_ADDR;
            addr_q  <= addr_i;
            data_q  <= wdata_i;
            word_q  <= word_i;
            fetch_q <= 1'b0;
          end else if (rd_i) begin
            state_q <= ST_RD_ADDR;
            addr_q  <= addr_i;
            word_q  <= word_i;
            fetch_q <= fetch_i;
          end else if (halt_i) begin
            state_q <= ST_HALT;
            data_q  <= reason_i;
            word_q  <= 1'b1;
            fetch_q <= 1'b0;
          end
        end
        ST_RD_ADDR: state_q <= ST_RD_DATA;
        ST_WR_ADDR: state_q <= ST_WR_DATA;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign lane_mask_o[7:0] = 8'hFF;
    end else begin : g_high
      assign lane_mask_o[g*8 +: 8] = {8{word_q}};
    end
  end

  assign state_o = state_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign word_o  = word_q;
  assign fetch_o = fetch_q;

  // R2 / R5: address phase always followed by its own data phase
  a_r2_rd_addr_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RD_ADDR |=> state_q == ST_RD_DATA);
  a_r5_wr_addr_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WR_ADDR |=> state_q == ST_WR_DATA);
  // R9: no acceptance while busy, latched address stable mid-transaction
  a_r9_addr_stable_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ADDR || state_q == ST_WR_ADDR) |=> $stable(addr_q));
endmodule

// File: rtl/hbus_drive.sv
module hbus_drive
  import hbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  hbus_state_e   state_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          word_i,
  input  logic [DW-1:0] lane_mask_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          word_o,
  output logic          halted_o
);
  always_comb begin
    bus_o    = '0;
    bus_oe_o = 1'b0;
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    halted_o = 1'b0;
    unique case (state_i)
      ST_RD_ADDR: begin bus_o = addr_i; bus_oe_o = 1'b1; mem_rd_o = 1'b1; end
      ST_WR_ADDR: begin bus_o = addr_i; bus_oe_o = 1'b1; mem_wr_o = 1'b1; end
      ST_WR_DATA: begin bus_o = data_i & lane_mask_i; bus_oe_o = 1'b1; end
      ST_HALT:    begin bus_o = data_i; bus_oe_o = 1'b1; halted_o = 1'b1; end
      default: ;
    endcase
  end

  assign word_o = (state_i != ST_IDLE) && word_i;

  a_r9_rd_wr_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  // R8: released bus during the read data phase
  a_r8_release_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !bus_oe_o && !mem_rd_o);
  a_r7_halt_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> bus_oe_o && word_o);
endmodule

// File: rtl/hbus_capture.sv
module hbus_capture
  import hbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  hbus_state_e   state_i,
  input  logic          fetch_i,
  input  logic [DW-1:0] lane_mask_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic [DW-1:0] ir_o
);
  logic          cap;
  logic [DW-1:0] masked;
  logic [DW-1:0] rdata_q, ir_q;
  logic          rvalid_q;

  assign cap    = (state_i == ST_RD_DATA);
  assign masked = bus_i & lane_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      ir_q     <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cap;
      if (cap) rdata_q <= masked;
      if (cap && fetch_i) ir_q <= masked;
    end
  end

  // instruction path is transparent only in the fetch data phase
  assign ir_o     = (cap && fetch_i) ? masked : ir_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  a_r3_rdata_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(rdata_q));
  a_r6_ir_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap && fetch_i) |=> $stable(ir_q));
endmodule

// File: rtl/hbus_bridge.sv
module hbus_bridge
  import hbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  input  logic          core_rd_i,
  input  logic          core_wr_i,
  input  logic          core_halt_i,
  input  logic          core_word_i,
  input  logic          core_fetch_i,
  input  logic [DW-1:0] core_addr_i,
  input  logic [DW-1:0] core_wdata_i,
  input  logic [DW-1:0] core_reason_i,
  output logic          core_busy_o,
  output logic [DW-1:0] core_rdata_o,
  output logic          core_rvalid_o,
  output logic [DW-1:0] core_ir_o,
  output logic          core_irq_o,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          word_o,
  output logic          halted_o
);
  hbus_state_e   state;
  logic [DW-1:0] addr_q, data_q, lane_mask;
  logic          word_q, fetch_q, irq_q;

  hbus_seq #(.DW(DW)) u_seq (
    .clk_i, .rst_ni,
    .rd_i(core_rd_i), .wr_i(core_wr_i), .halt_i(core_halt_i),
    .word_i(core_word_i), .fetch_i(core_fetch_i),
    .addr_i(core_addr_i), .wdata_i(core_wdata_i), .reason_i(core_reason_i),
    .state_o(state), .addr_o(addr_q), .data_o(data_q),
    .word_o(word_q), .fetch_o(fetch_q), .lane_mask_o(lane_mask)
  );

  hbus_drive #(.DW(DW)) u_drive (
    .clk_i, .rst_ni,
    .state_i(state), .addr_i(addr_q), .data_i(data_q),
    .word_i(word_q), .lane_mask_i(lane_mask),
    .bus_o, .bus_oe_o, .mem_rd_o, .mem_wr_o, .word_o, .halted_o
  );

  hbus_capture #(.DW(DW)) u_capture (
    .clk_i, .rst_ni,
    .state_i(state), .fetch_i(fetch_q), .lane_mask_i(lane_mask), .bus_i,
    .rdata_o(core_rdata_o), .rvalid_o(core_rvalid_o), .ir_o(core_ir_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_i;
  end

  assign core_irq_o  = irq_q;
  assign core_busy_o = (state != ST_IDLE);

  a_r3_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rvalid_o |-> $past(mem_rd_o, 2));
  a_r4_byte_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rvalid_o && !$past(word_o, 2)) |-> core_rdata_o[DW-1:8] == '0);
  a_r5_wr_data_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> bus_oe_o && !mem_wr_o && core_busy_o);
  a_r8_oe_only_in_phases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (mem_rd_o || mem_wr_o || halted_o || $past(mem_wr_o)));
  a_r10_busy_in_phases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o || halted_o) |-> core_busy_o);
  a_r11_irq_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_irq_o == $past(irq_i));
endmodule

// File: tb/hbus_bridge_bench.sv
module hbus_bridge_bench;
  localparam int DW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic irq_i = 1'b0;
  logic core_rd_i = 1'b0, core_wr_i = 1'b0, core_halt_i = 1'b0;
  logic core_word_i = 1'b0, core_fetch_i = 1'b0;
  logic [DW-1:0] core_addr_i = '0, core_wdata_i = '0, core_reason_i = '0;
  logic core_busy_o, core_rvalid_o, core_irq_o;
  logic [DW-1:0] core_rdata_o, core_ir_o;
  logic [DW-1:0] bus_i = '0, bus_o;
  logic bus_oe_o, mem_rd_o, mem_wr_o, word_o, halted_o;

  int checks = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  hbus_bridge #(.DW(DW)) u_hbus_bridge (.*);

  // host model: byte memory, samples at falling edge
  logic [7:0] hmem [32];
  logic [7:0] shadow [32];
  logic hold = 1'b0, pend_wr = 1'b0, pend_word = 1'b0;
  logic [4:0] pend_addr = '0;
  logic [15:0] junk = 16'hDEAD;

  always @(negedge clk_i) begin
    junk <= junk * 16'd5 + 16'd13;
    if (mem_rd_o) begin
      if (word_o) bus_i <= {hmem[{bus_o[4:1], 1'b1}], hmem[{bus_o[4:1], 1'b0}]};
      else        bus_i <= {8'hA5, hmem[bus_o[4:0]]};
      hold <= 1'b1;
    end else if (hold) begin
      hold <= 1'b0;
    end else begin
      bus_i <= junk;
    end
    if (mem_wr_o) begin
      pend_wr <= 1'b1; pend_addr <= bus_o[4:0]; pend_word <= word_o;
    end else if (pend_wr) begin
      pend_wr <= 1'b0;
      if (pend_word) begin
        hmem[{pend_addr[4:1], 1'b0}] <= bus_o[7:0];
        hmem[{pend_addr[4:1], 1'b1}] <= bus_o[15:8];
      end else begin
        hmem[pend_addr] <= bus_o[7:0];
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk_i);
    #1;
  endtask

  function automatic logic [15:0] exp_rd(input logic [4:0] a, input logic w);
    if (w) return {shadow[{a[4:1], 1'b1}], shadow[{a[4:1], 1'b0}]};
    return {8'h00, shadow[a]};
  endfunction

  task automatic do_read(input logic [4:0] a, input logic w, input logic f);
    logic [15:0] e, ir_before;
    e = exp_rd(a, w);
    ir_before = core_ir_o;
    core_rd_i = 1'b1; core_addr_i = {11'h0, a}; core_word_i = w; core_fetch_i = f;
    tick;
    core_rd_i = 1'b0; core_fetch_i = 1'b0;
    chk(mem_rd_o && bus_oe_o && !mem_wr_o, "R2 rd strobe", {mem_rd_o, bus_oe_o}, 2'b11);
    chk(bus_o == {11'h0, a}, "R2 address", bus_o, {11'h0, a});
    chk(word_o == w, "R2 width", word_o, w);
    chk(core_busy_o, "R10 busy addr", core_busy_o, 1);
    tick;
    chk(!bus_oe_o && !mem_rd_o && !mem_wr_o, "R3 R8 released",
        {bus_oe_o, mem_rd_o, mem_wr_o}, 0);
    if (f) chk(core_ir_o == e, "R6 ir transparent", core_ir_o, e);
    tick;
    chk(core_rvalid_o && core_rdata_o == e, "R3 R4 rdata", core_rdata_o, e);
    chk(!core_busy_o, "R10 idle", core_busy_o, 0);
    chk(core_ir_o == (f ? e : ir_before), "R6 ir held", core_ir_o, f ? e : ir_before);
    tick;
    chk(!core_rvalid_o && core_rdata_o == e, "R3 persist", core_rdata_o, e);
  endtask

  task automatic do_write(input logic [4:0] a, input logic w, input logic [15:0] d);
    logic [15:0] ed;
    ed = w ? d : {8'h00, d[7:0]};
    core_wr_i = 1'b1; core_addr_i = {11'h0, a}; core_word_i = w; core_wdata_i = d;
    tick;
    core_wr_i = 1'b0;
    chk(mem_wr_o && bus_oe_o && !mem_rd_o, "R5 wr strobe", {mem_wr_o, bus_oe_o}, 2'b11);
    chk(bus_o == {11'h0, a} && word_o == w, "R5 address", bus_o, {11'h0, a});
    tick;
    chk(bus_oe_o && !mem_wr_o && bus_o == ed, "R5 R4 wr data", bus_o, ed);
    if (w) begin
      shadow[{a[4:1], 1'b0}] = d[7:0];
      shadow[{a[4:1], 1'b1}] = d[15:8];
    end else shadow[a] = d[7:0];
    tick;
    chk(!bus_oe_o && !core_busy_o, "R8 R10 after write", bus_oe_o, 0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      hmem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    tick;
    chk(!mem_rd_o && !mem_wr_o && !halted_o && !bus_oe_o && !word_o,
        "R1 reset strobes", {mem_rd_o, mem_wr_o, halted_o, bus_oe_o}, 0);
    tick;
    rst_ni = 1'b1;
    tick;
    chk(!core_busy_o && !core_rvalid_o && !bus_oe_o, "R1 after reset busy", core_busy_o, 0);
    chk(core_rdata_o == 0 && core_ir_o == 0, "R1 data regs", core_rdata_o, 0);

    // R2 R3 R4 R6: sweep every address, byte and word, fetch and plain
    for (int a = 0; a < 32; a++) do_read(5'(a), 1'b0, 1'b0);
    for (int a = 0; a < 32; a += 2) do_read(5'(a), 1'b1, a[1]);

    // R5 R4: word writes low half, byte writes high half, then read back
    for (int a = 0; a < 16; a += 2) do_write(5'(a), 1'b1, 16'(a * 16'h1111 ^ 16'h5A3C));
    for (int a = 16; a < 32; a++) do_write(5'(a), 1'b0, 16'hC300 | 16'(a * 9));
    for (int a = 0; a < 32; a += 2) do_read(5'(a), 1'b1, 1'b0);
    for (int a = 0; a < 32; a++) do_read(5'(a), 1'b0, 1'b1);

    // R7 halt
    core_halt_i = 1'b1; core_reason_i = 16'hBEEF;
    tick;
    core_halt_i = 1'b0;
    chk(halted_o && bus_oe_o && word_o && bus_o == 16'hBEEF, "R7 halt phase", bus_o, 16'hBEEF);
    chk(core_busy_o && !mem_rd_o && !mem_wr_o, "R7 R10 halt busy", core_busy_o, 1);
    tick;
    chk(!halted_o && !bus_oe_o && !core_busy_o, "R7 halt ends", halted_o, 0);

    // R9 priority: write beats read and halt
    core_wr_i = 1'b1; core_rd_i = 1'b1; core_halt_i = 1'b1;
    core_addr_i = 16'h0006; core_word_i = 1'b1; core_wdata_i = 16'h1234; core_reason_i = 16'h7777;
    tick;
    core_wr_i = 1'b0; core_rd_i = 1'b0; core_halt_i = 1'b0;
    chk(mem_wr_o && !mem_rd_o && !halted_o, "R9 write wins", {mem_wr_o, mem_rd_o, halted_o}, 3'b100);
    tick;
    shadow[6] = 8'h34; shadow[7] = 8'h12;
    tick;
    // read beats halt
    core_rd_i = 1'b1; core_halt_i = 1'b1; core_addr_i = 16'h0006; core_word_i = 1'b1;
    tick;
    core_rd_i = 1'b0; core_halt_i = 1'b0;
    chk(mem_rd_o && !halted_o, "R9 read wins", {mem_rd_o, halted_o}, 2'b10);
    tick;
    tick;
    chk(core_rdata_o == 16'h1234, "R9 R5 write landed", core_rdata_o, 16'h1234);
    chk(!halted_o, "R9 halt dropped", halted_o, 0);

    // R9 requests while busy are ignored
    core_rd_i = 1'b1; core_addr_i = 16'h0004; core_word_i = 1'b1;
    tick;
    core_addr_i = 16'h0008; core_wr_i = 1'b1; core_wdata_i = 16'hFFFF;
    tick;
    core_rd_i = 1'b0; core_wr_i = 1'b0;
    tick;
    chk(core_rdata_o == exp_rd(5'd4, 1'b1), "R9 busy read kept", core_rdata_o, exp_rd(5'd4, 1'b1));
    chk(!mem_rd_o && !mem_wr_o && !core_busy_o, "R9 busy req ignored",
        {mem_rd_o, mem_wr_o}, 0);
    do_read(5'd8, 1'b1, 1'b0);

    // R11 irq
    irq_i = 1'b1;
    #1;
    chk(core_irq_o == 1'b0, "R11 irq before edge", core_irq_o, 0);
    tick;
    chk(core_irq_o == 1'b1, "R11 irq rise", core_irq_o, 1);
    irq_i = 1'b0;
    tick;
    chk(core_irq_o == 1'b0, "R11 irq fall", core_irq_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule